// File: doc/BRIEF.md
# UART Receive Line Status Tracker

This block is the receive-side status path of a 16550-style serial port. Every character handed over by the deserializer is stored together with three error tags of its own (break, framing error, parity error). The block presents a five-bit line status word and a receiver line status interrupt. Error tags are reported only when their character reaches the head of the receive store, so software sees the status of the exact character it is about to read.

Two modes are supported. With the FIFO enabled the store holds up to `DEPTH` characters. With it disabled the same storage acts as a single holding register. In both modes the status bits for errors and overrun are sticky. A read of the status register clears them. A character that arrives while the store is full is discarded and flags an overrun.

The CPU side uses two single-cycle read strobes, one for the data register and one for the status register. The head character and the status word are always visible combinationally, so the status can be read before the character is popped.

Top module: `uart_rx_status`

## Requirements
- R1: `lineStatus[0]` (data ready) is 1 exactly when at least one character is stored. `rdData` shows the oldest stored character. A `dataRd` pulse removes that character, so characters come out in arrival order.
- R2: With `fifoEn`=1 the store holds 16 characters. A character presented while 16 are held is discarded, and `lineStatus[1]` (overrun) is 1 from the next cycle. This holds even if a `dataRd` occurs in the same cycle.
- R3: With `fifoEn`=0 the store holds one character. A second character arriving before the first is read is discarded and sets overrun. The held character stays on `rdData`.
- R4: `lineStatus[4]`, `[3]` and `[2]` are break, framing error and parity error. They show the tags of the head character from the first cycle it is at the head. Tags of characters behind the head have no effect until the characters ahead of them have been read.
- R5: Once set, `lineStatus[4:1]` stay set until a `statusRd` pulse, which clears them in the next cycle. An overrun raised in the same cycle as `statusRd` survives the clear.
- R6: `lsIrq` is 1 exactly when `intEn` is 1 and any of `lineStatus[4:1]` is 1.
- R7: A `dataRd` pulse while the store is empty has no effect on the stored characters or on the status.
- R8: A change of `fifoEn` empties the store in the cycle it is seen, and a character presented in that cycle is dropped without an overrun. Sticky bits `lineStatus[4:1]` are left as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | 1 selects the 16-entry store, 0 the single holding register |
| intEn | input | 1 | Enables the line status interrupt |
| rxValid | input | 1 | One-cycle strobe: a received character is presented |
| rxData | input | 8 | Received character |
| rxParErr | input | 1 | Parity error tag of the presented character |
| rxFrmErr | input | 1 | Framing error tag of the presented character |
| rxBrk | input | 1 | Break tag of the presented character |
| dataRd | input | 1 | CPU read strobe of the receive data register |
| statusRd | input | 1 | CPU read strobe of the line status register |
| rdData | output | 8 | Head character (0 when empty) |
| lineStatus | output | 5 | {break, framing, parity, overrun, data ready} |
| lsIrq | output | 1 | Receiver line status interrupt |

## Verification
The assertions check on every cycle the rules that follow from one cycle to the next. The occupancy never exceeds the capacity of the current mode. A character presented to a full store always raises overrun. Overrun holds until a status read and drops after one that had no arriving character. The interrupt stays low while disabled, and data ready follows the first push and the last pop.

Only the bench's scenarios can show end-to-end behaviour: that the error tags of a bad character wait behind earlier characters and surface exactly when it reaches the head, that data leaves in arrival order, and that a mode change flushes the store but keeps the sticky bits.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

  // Error tags carried with each stored character.
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } errTag_t;

  localparam int TAG_W = $bits(errTag_t);

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;      // write the presented character
    logic pop;       // drop the head character
    logic flush;     // empty the store
    logic latchHead; // head character seen for the first time
    logic clrStat;   // status register read
    logic setOvr;    // character discarded because the store is full
  } rxsCtl_t;

endpackage

// File: rtl/uart_rxs_dp.sv
module uart_rxs_dp
  import uart_rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxsCtl_t           ctl,
  input  logic [DATA_W-1:0] wrData,
  input  errTag_t           wrTag,
  output logic [DATA_W-1:0] headData,
  output errTag_t           headTag,
  output logic [CNT_W-1:0]  occ,
  output errTag_t           errView,
  output logic              ovrFlag
);

  logic [DATA_W-1:0] dataMem [DEPTH];
  errTag_t           tagMem  [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  errTag_t           stickyErr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage array: no reset needed, occupancy qualifies every read.
  always_ff @(posedge clk) begin
    if (ctl.push) begin
      dataMem[wrPtr] <= wrData;
      tagMem[wrPtr]  <= wrTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (ctl.push) wrPtr <= bump(wrPtr);
      if (ctl.pop)  rdPtr <= bump(rdPtr);
      unique case ({ctl.push, ctl.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign headData = dataMem[rdPtr];
  assign headTag  = tagMem[rdPtr];

  // Sticky error and overrun bits.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyErr <= '0;
      ovrFlag   <= 1'b0;
    end else begin
      if (ctl.clrStat)        stickyErr <= '0;
      else if (ctl.latchHead) stickyErr <= stickyErr | headTag;

      if (ctl.setOvr)       ovrFlag <= 1'b1;
      else if (ctl.clrStat) ovrFlag <= 1'b0;
    end
  end

  // A new head shows its tags in the same cycle it reaches the head.
  assign errView = stickyErr | (ctl.latchHead ? headTag : '0);

endmodule

// File: rtl/uart_rxs_ctl.sv
module uart_rxs_ctl
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             rxValid,
  input  logic             dataRd,
  input  logic             statusRd,
  input  logic [CNT_W-1:0] occ,
  output rxsCtl_t          ctl,
  output logic             modeQ
);

  localparam logic [CNT_W-1:0] CAP_FIFO = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_HOLD = CNT_W'(1);

  logic             headSeen;
  logic [CNT_W-1:0] capacity;
  logic             isFull, isEmpty;

  assign capacity = modeQ ? CAP_FIFO : CAP_HOLD;
  assign isFull   = (occ == capacity);
  assign isEmpty  = (occ == '0);

  always_comb begin
    ctl           = '0;
    ctl.flush     = (fifoEn != modeQ);
    ctl.latchHead = !isEmpty && !headSeen;
    ctl.clrStat   = statusRd;
    if (!ctl.flush) begin
      ctl.pop    = dataRd && !isEmpty;
      ctl.push   = rxValid && !isFull;
      ctl.setOvr = rxValid && isFull;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      headSeen <= 1'b0;
    end else begin
      modeQ <= fifoEn;
      if (ctl.flush || ctl.pop) headSeen <= 1'b0;
      else if (ctl.latchHead)   headSeen <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic              intEn,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  input  logic              rxBrk,
  input  logic              dataRd,
  input  logic              statusRd,
  output logic [DATA_W-1:0] rdData,
  output logic [4:0]        lineStatus,
  output logic              lsIrq
);

  rxsCtl_t           ctl;
  logic              modeQ;
  logic [CNT_W-1:0]  occ;
  logic [DATA_W-1:0] headData;
  errTag_t           headTag, errView, wrTag;
  logic              ovrFlag;

  assign wrTag = '{brk: rxBrk, frm: rxFrmErr, par: rxParErr};

  uart_rxs_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxValid(rxValid),
    .dataRd(dataRd), .statusRd(statusRd), .occ(occ),
    .ctl(ctl), .modeQ(modeQ)
  );

  uart_rxs_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(rxData), .wrTag(wrTag),
    .headData(headData), .headTag(headTag), .occ(occ),
    .errView(errView), .ovrFlag(ovrFlag)
  );

  assign rdData     = (occ != '0) ? headData : '0;
  assign lineStatus = {errView.brk, errView.frm, errView.par, ovrFlag, occ != '0};
  assign lsIrq      = intEn && (|lineStatus[4:1]);

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEn,
  input logic             intEn,
  input logic             rxValid,
  input logic             dataRd,
  input logic             statusRd,
  input logic [4:0]       lineStatus,
  input logic             lsIrq,
  input logic [CNT_W-1:0] occ,
  input logic             modeQ
);

  logic [CNT_W-1:0] cap;
  logic             steady;
  assign cap    = modeQ ? CNT_W'(DEPTH) : CNT_W'(1);
  assign steady = (fifoEn == modeQ);

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    occ <= cap); // R2

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && steady && occ == cap) |=> lineStatus[1]); // R3

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lineStatus[1] && !statusRd) |=> lineStatus[1]); // R5

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !rxValid) |=> !lineStatus[1]); // R5

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !lsIrq); // R6

  AST_DR_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && steady && occ == '0) |=> lineStatus[0]); // R1

  AST_DR_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !rxValid && steady && occ == CNT_W'(1)) |=> !lineStatus[0]); // R1

endmodule

bind uart_rx_status uart_rx_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .intEn(intEn),
  .rxValid(rxValid), .dataRd(dataRd), .statusRd(statusRd),
  .lineStatus(lineStatus), .lsIrq(lsIrq), .occ(occ), .modeQ(modeQ)
);

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b0, intEn = 1'b0;
  logic       rxValid = 1'b0, rxParErr = 1'b0, rxFrmErr = 1'b0, rxBrk = 1'b0;
  logic [7:0] rxData = '0;
  logic       dataRd = 1'b0, statusRd = 1'b0;
  logic [7:0] rdData;
  logic [4:0] lineStatus;
  logic       lsIrq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_status u0 (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .intEn(intEn),
    .rxValid(rxValid), .rxData(rxData), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxBrk(rxBrk), .dataRd(dataRd),
    .statusRd(statusRd), .rdData(rdData), .lineStatus(lineStatus),
    .lsIrq(lsIrq)
  );

  // Reference model state
  logic [10:0] mq[$];      // {tag[2:0] as brk,frm,par ; data}
  bit          mMode = 0, mSeen = 0, mOvr = 0;
  logic [2:0]  mSticky = '0;

  function automatic bit mLatch();
    return (mq.size() > 0) && !mSeen;
  endfunction

  function automatic logic [4:0] mLsr();
    logic [2:0] e;
    e = mSticky | (mLatch() ? mq[0][10:8] : 3'b000);
    return {e, mOvr, mq.size() > 0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [4:0] e;
    e = mLsr();
    chk("R1 data ready", 32'(lineStatus[0]), 32'(e[0]));
    if (mq.size() > 0) chk("R1 head data", 32'(rdData), 32'(mq[0][7:0]));
    chk("R2 overrun", 32'(lineStatus[1]), 32'(e[1]));
    chk("R4 error bits", 32'(lineStatus[4:2]), 32'(e[4:2]));
    chk("R6 interrupt", 32'(lsIrq), 32'(intEn && (|e[4:1])));
  endtask

  task automatic modelUpdate(input bit v, input logic [7:0] d, input logic [2:0] t,
                             input bit dr, input bit sr);
    bit latch, flush, full, pop;
    int cap;
    latch = mLatch();
    flush = (fifoEn != mMode);
    if (sr) mSticky = '0;
    else if (latch) mSticky = mSticky | mq[0][10:8];
    if (flush) begin
      if (sr) mOvr = 0;
      mq.delete();
      mSeen = 0;
      mMode = fifoEn;
    end else begin
      cap  = mMode ? DEPTH : 1;
      full = (mq.size() == cap);
      pop  = dr && (mq.size() > 0);
      if (v && full) mOvr = 1;
      else if (sr) mOvr = 0;
      if (pop) begin
        void'(mq.pop_front());
        mSeen = 0;
      end else if (latch) mSeen = 1;
      if (v && !full) mq.push_back({t, d});
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit v, input logic [7:0] d, input logic [2:0] t,
                      input bit dr, input bit sr);
    rxValid = v; rxData = d; {rxBrk, rxFrmErr, rxParErr} = t;
    dataRd = dr; statusRd = sr;
    #1;
    compareAll();
    @(posedge clk);
    modelUpdate(v, d, t, dr, sr);
    @(negedge clk);
    rxValid = 0; dataRd = 0; statusRd = 0;
  endtask

  task automatic idle();
    step(0, 8'h00, 3'b000, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 reset status", 32'(lineStatus), 32'h0);
    chk("R6 reset irq", 32'(lsIrq), 32'h0);
    @(negedge clk);

    // R3: single holding register
    intEn = 1;
    step(1, 8'hA5, 3'b000, 0, 0);
    step(1, 8'h3C, 3'b000, 0, 0);
    chk("R3 overrun set", 32'(lineStatus[1]), 32'h1);
    chk("R3 held char kept", 32'(rdData), 32'hA5);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R3 second char discarded", 32'(lineStatus[0]), 32'h0);

    // R5: sticky overrun, cleared by a status read
    idle();
    chk("R5 overrun sticky", 32'(lineStatus[1]), 32'h1);
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R5 cleared by status read", 32'(lineStatus[4:1]), 32'h0);

    // R7: read of empty store
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R7 empty read ignored", 32'(lineStatus), 32'h0);

    // R8: mode change keeps sticky bits and flushes
    step(1, 8'h11, 3'b000, 0, 0);
    step(1, 8'h22, 3'b000, 0, 0);
    fifoEn = 1;
    step(1, 8'h33, 3'b000, 0, 0);
    chk("R8 store flushed", 32'(lineStatus[0]), 32'h0);
    chk("R8 sticky overrun kept", 32'(lineStatus[1]), 32'h1);
    step(0, 8'h00, 3'b000, 0, 1);

    // R2 and R4: fill 16 with a parity-bad third character, then one more
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(8'h40 + i), (i == 2) ? 3'b001 : 3'b000, 0, 0);
    chk("R4 bad char not at head", 32'(lineStatus[4:2]), 32'h0);
    step(1, 8'hEE, 3'b100, 0, 0);
    chk("R2 overrun when full", 32'(lineStatus[1]), 32'h1);
    step(0, 8'h00, 3'b000, 1, 0);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R4 parity at head", 32'(lineStatus[4:2]), 32'h1);
    chk("R4 head data", 32'(rdData), 32'h42);
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R5 errors cleared", 32'(lineStatus[4:1]), 32'h0);
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 3'b000, 1, 0);
    chk("R1 drained", 32'(lineStatus[0]), 32'h0);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] t;
      t = ($urandom_range(3) == 0) ? 3'($urandom) : 3'b000;
      if ($urandom_range(249) == 0) fifoEn = ~fifoEn;
      if ($urandom_range(99) == 0) intEn = ~intEn;
      step($urandom_range(1), 8'($urandom), t,
           $urandom_range(9) < 4, $urandom_range(9) == 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule